// File: doc/BRIEF.md
# User-Level Interrupt CSR Unit

This block gives a hart that handles interrupts in user mode its user-level control and status registers. A single CSR port carries an address, write data and a write strobe, and returns read data together with a flag that marks an unknown address. The user status, interrupt-enable and interrupt-pending registers are not separate storage. They are narrow windows onto state that the supervisor and machine levels share. The block holds that shared state, exposes it on dedicated outputs, and writes each user-level update back into it through a bit-by-bit legalization rule.

A delegation mask arrives as an input. It decides which interrupt kinds (software, timer, external) are visible through the user windows and which ones user writes may change. The hardware pending lines for timer and external interrupts drive their shared pending bits. A hardware pulse can raise the software pending bit. A machine-side load port replaces the whole shared status word. Five plain user trap registers complete the set: vector, scratch, exception PC, cause and trap value.

Top module: `user_irq_csr`

## Requirements
- R1: A read of the status register (address 0x000) returns shared status bit 0 (enable) and bit 4 (previous enable) in place, with every other bit zero.
- R2: A user write to 0x000 changes only bits 0 and 4 of the shared status word, and all other bits keep their value. A machine load replaces the whole word. When a machine load and a user write fall in the same cycle, the machine load wins.
- R3: A read of the pending register (0x044) returns the shared pending bits ANDed with the delegation mask: software at bit 0, timer at bit 4, external at bit 8. All other bits are zero.
- R4: A read of the enable register (0x004) returns the shared enable bits ANDed with the delegation mask, using the same bit positions as R3.
- R5: A write to 0x044 changes only the software pending bit, and only when mask bit 0 is 1. The timer and external pending bits take the level of their hardware inputs one cycle later. User writes never affect them.
- R6: A write to 0x004 updates each enable bit (positions 0, 4, 8) only where the matching mask bit is 1. Every other enable bit keeps its value.
- R7: A hardware set pulse raises the software pending bit. If a delegated user write of that bit lands in the same cycle, the written value wins.
- R8: Valid addresses are 0x000, 0x004, 0x005, 0x040, 0x041, 0x042, 0x043 and 0x044. Any other address reads zero, raises the illegal flag, and ignores writes.
- R9: The exception PC (0x041) stores the written word with bit 0 forced to zero. Scratch (0x040), cause (0x042) and trap value (0x043) store the written word unchanged.
- R10: The trap vector (0x005) keeps base bits [XLEN-1:2]. It stores mode values 0 and 1 as written and turns modes 2 and 3 into 0.
- R11: Writes take effect at the rising clock edge. A read in the same cycle as a write returns the old value.
- R12: An active-low asynchronous reset clears every held bit, so that all registers and shared outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_addr | input | 12 | CSR address |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data for csr_addr (combinational, from held state) |
| csr_illegal | output | 1 | csr_addr is not a register of this block |
| deleg_mask | input | XLEN | Supervisor-to-user delegation mask (bits 0, 4, 8 used) |
| hw_ext_pend | input | 1 | Hardware external-interrupt pending level |
| hw_tim_pend | input | 1 | Hardware timer-interrupt pending level |
| hw_sw_set | input | 1 | Hardware pulse that sets the software pending bit |
| m_status_ld | input | 1 | Machine-side load of the shared status word |
| m_status_val | input | XLEN | Value for the machine-side load |
| status_o | output | XLEN | Shared status word |
| irq_pend_o | output | 3 | Shared pending bits {external, timer, software} |
| irq_en_o | output | 3 | Shared enable bits {external, timer, software} |

## Verification
The bench builds the block with the default XLEN of 32. That width is enough to place bit 8 of the pending and enable windows, a cause word with its interrupt flag in bit 31, and trap-vector bases far above the mode field. With it, the bench can show that the masked views clear every non-delegated bit. It can also show that the shared status word keeps all 30 bits outside the user window across user writes. The bench steps the delegation mask through single kinds and pairs of kinds, so that each per-bit write rule is tested both delegated and not delegated.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int unsigned CSR_AW = 12;

    // register addresses
    localparam logic [CSR_AW-1:0] ADR_STAT  = 12'h000;
    localparam logic [CSR_AW-1:0] ADR_IE    = 12'h004;
    localparam logic [CSR_AW-1:0] ADR_TVEC  = 12'h005;
    localparam logic [CSR_AW-1:0] ADR_SCR   = 12'h040;
    localparam logic [CSR_AW-1:0] ADR_EPC   = 12'h041;
    localparam logic [CSR_AW-1:0] ADR_CAUSE = 12'h042;
    localparam logic [CSR_AW-1:0] ADR_TVAL  = 12'h043;
    localparam logic [CSR_AW-1:0] ADR_IP    = 12'h044;

    // status window bits
    localparam int unsigned BIT_EN   = 0;
    localparam int unsigned BIT_PREV = 4;

    // interrupt kinds: kind k lives at bit k*KIND_STRIDE of the windows
    localparam int unsigned NKIND       = 3;
    localparam int unsigned KIND_STRIDE = 4;
    localparam int unsigned K_SW        = 0;
    localparam int unsigned K_TIM       = 1;
    localparam int unsigned K_EXT       = 2;
    localparam int unsigned TOP_KIND_BIT = (NKIND - 1) * KIND_STRIDE;

    // trap vector modes
    localparam logic [1:0] TV_DIRECT = 2'd0;

    typedef enum logic [3:0] {
        R_NONE, R_STAT, R_IE, R_IP, R_TVEC, R_SCR, R_EPC, R_CAUSE, R_TVAL
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [CSR_AW-1:0] a);
        reg_sel_e s;
        case (a)
            ADR_STAT:  s = R_STAT;
            ADR_IE:    s = R_IE;
            ADR_IP:    s = R_IP;
            ADR_TVEC:  s = R_TVEC;
            ADR_SCR:   s = R_SCR;
            ADR_EPC:   s = R_EPC;
            ADR_CAUSE: s = R_CAUSE;
            ADR_TVAL:  s = R_TVAL;
            default:   s = R_NONE;
        endcase
        return s;
    endfunction

    // modes 2 and 3 are reserved and fall back to direct
    function automatic logic [1:0] legal_mode(input logic [1:0] m);
        return m[1] ? TV_DIRECT : m;
    endfunction

endpackage

// File: rtl/uirq_status_view.sv
module uirq_status_view
    import uirq_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wdata,
    input  logic            m_ld,
    input  logic [XLEN-1:0] m_ld_val,
    output logic [XLEN-1:0] status_o,
    output logic [XLEN-1:0] view_o
);

    localparam logic [XLEN-1:0] VIEW_MASK =
        (XLEN'(1) << BIT_EN) | (XLEN'(1) << BIT_PREV);

    typedef struct packed {
        logic [XLEN-1:0] word;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (m_ld) begin
            st_d.word = m_ld_val;
        end else if (wr_en) begin
            st_d.word = (st_q.word & ~VIEW_MASK) | (wdata & VIEW_MASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.word;
    assign view_o   = st_q.word & VIEW_MASK;

    // R2: without a machine load, bits outside the user window never move
    p_keep_other_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !m_ld |=> ((status_o & ~VIEW_MASK) == $past(status_o & ~VIEW_MASK)));

    // R2: a machine load takes the whole word, even against a user write
    p_mload_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        m_ld |=> (status_o == $past(m_ld_val)));

endmodule

// File: rtl/uirq_intr_view.sv
module uirq_intr_view
    import uirq_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ip,
    input  logic             wr_ie,
    input  logic [XLEN-1:0]  wdata,
    input  logic [XLEN-1:0]  dmask,
    input  logic             hw_ext,
    input  logic             hw_tim,
    input  logic             hw_sw_set,
    output logic [NKIND-1:0] pend_o,
    output logic [NKIND-1:0] en_o,
    output logic [XLEN-1:0]  ip_view_o,
    output logic [XLEN-1:0]  ie_view_o
);

    typedef struct packed {
        logic [NKIND-1:0] pend;
        logic [NKIND-1:0] en;
    } ir_t;

    ir_t ir_d, ir_q;

    logic unused_bits;
    assign unused_bits = ^{wdata, dmask};

    always_comb begin
        ir_d = ir_q;
        // hardware levels own the timer and external pending bits
        ir_d.pend[K_EXT] = hw_ext;
        ir_d.pend[K_TIM] = hw_tim;
        if (hw_sw_set) begin
            ir_d.pend[K_SW] = 1'b1;
        end
        // a delegated user write of the software bit overrides the hardware set
        if (wr_ip && dmask[K_SW*KIND_STRIDE]) begin
            ir_d.pend[K_SW] = wdata[K_SW*KIND_STRIDE];
        end
        for (int k = 0; k < NKIND; k++) begin
            if (wr_ie && dmask[k*KIND_STRIDE]) begin
                ir_d.en[k] = wdata[k*KIND_STRIDE];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ir_q <= '0;
        else        ir_q <= ir_d;
    end

    always_comb begin
        ip_view_o = '0;
        ie_view_o = '0;
        for (int k = 0; k < NKIND; k++) begin
            ip_view_o[k*KIND_STRIDE] = ir_q.pend[k] & dmask[k*KIND_STRIDE];
            ie_view_o[k*KIND_STRIDE] = ir_q.en[k]   & dmask[k*KIND_STRIDE];
        end
    end

    assign pend_o = ir_q.pend;
    assign en_o   = ir_q.en;

    // R6: an enable bit whose kind is not delegated keeps its value
    for (genvar g = 0; g < NKIND; g++) begin : g_en_chk
        p_en_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !dmask[g*KIND_STRIDE] |=> $stable(en_o[g]));
    end

    // R5: timer and external pending follow their hardware level a cycle later
    p_ext_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hw_ext |=> pend_o[K_EXT]);
    p_ext_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_ext |=> !pend_o[K_EXT]);
    p_tim_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hw_tim |=> pend_o[K_TIM]);

    // R5: without delegation and without a hardware set, software pending holds
    p_sw_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dmask[K_SW*KIND_STRIDE] && !hw_sw_set) |=> $stable(pend_o[K_SW]));

    // R7: a delegated user write beats a simultaneous hardware set
    p_sw_win_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ip && dmask[K_SW*KIND_STRIDE] && hw_sw_set)
        |=> (pend_o[K_SW] == $past(wdata[K_SW*KIND_STRIDE])));

endmodule

// File: rtl/uirq_trap_regs.sv
module uirq_trap_regs
    import uirq_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  reg_sel_e        sel,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] tvec_o,
    output logic [XLEN-1:0] scr_o,
    output logic [XLEN-1:0] epc_o,
    output logic [XLEN-1:0] cause_o,
    output logic [XLEN-1:0] tval_o
);

    typedef struct packed {
        logic [XLEN-1:0] tvec;
        logic [XLEN-1:0] scr;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] tval;
    } tr_t;

    tr_t tr_d, tr_q;

    always_comb begin
        tr_d = tr_q;
        if (we) begin
            case (sel)
                R_TVEC:  tr_d.tvec  = {wdata[XLEN-1:2], legal_mode(wdata[1:0])};
                R_SCR:   tr_d.scr   = wdata;
                R_EPC:   tr_d.epc   = {wdata[XLEN-1:1], 1'b0};
                R_CAUSE: tr_d.cause = wdata;
                R_TVAL:  tr_d.tval  = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tr_q <= '0;
        else        tr_q <= tr_d;
    end

    assign tvec_o  = tr_q.tvec;
    assign scr_o   = tr_q.scr;
    assign epc_o   = tr_q.epc;
    assign cause_o = tr_q.cause;
    assign tval_o  = tr_q.tval;

    // R9: a written exception PC keeps the upper bits and is always even
    p_epc_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == R_EPC)
        |=> (!epc_o[0] && epc_o[XLEN-1:1] == $past(wdata[XLEN-1:1])));

    // R10: reserved vector modes land as direct mode, base kept
    p_tvec_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == R_TVEC && wdata[1])
        |=> (tvec_o[1:0] == TV_DIRECT && tvec_o[XLEN-1:2] == $past(wdata[XLEN-1:2])));

endmodule

// File: rtl/user_irq_csr.sv
module user_irq_csr
    import uirq_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CSR_AW-1:0]    csr_addr,
    input  logic                 csr_we,
    input  logic [XLEN-1:0]      csr_wdata,
    output logic [XLEN-1:0]      csr_rdata,
    output logic                 csr_illegal,
    input  logic [XLEN-1:0]      deleg_mask,
    input  logic                 hw_ext_pend,
    input  logic                 hw_tim_pend,
    input  logic                 hw_sw_set,
    input  logic                 m_status_ld,
    input  logic [XLEN-1:0]      m_status_val,
    output logic [XLEN-1:0]      status_o,
    output logic [NKIND-1:0]     irq_pend_o,
    output logic [NKIND-1:0]     irq_en_o
);

    localparam logic [XLEN-1:0] KIND_POS_MASK =
        (XLEN'(1) << (K_SW  * KIND_STRIDE)) |
        (XLEN'(1) << (K_TIM * KIND_STRIDE)) |
        (XLEN'(1) << (K_EXT * KIND_STRIDE));
    localparam logic [XLEN-1:0] STAT_POS_MASK =
        (XLEN'(1) << BIT_EN) | (XLEN'(1) << BIT_PREV);

    reg_sel_e        sel;
    logic [XLEN-1:0] stat_view, ip_view, ie_view;
    logic [XLEN-1:0] tvec_q, scr_q, epc_q, cause_q, tval_q;

    assign sel = decode_addr(csr_addr);

    uirq_status_view #(.XLEN(XLEN)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (csr_we && sel == R_STAT),
        .wdata    (csr_wdata),
        .m_ld     (m_status_ld),
        .m_ld_val (m_status_val),
        .status_o (status_o),
        .view_o   (stat_view)
    );

    uirq_intr_view #(.XLEN(XLEN)) u_intr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ip     (csr_we && sel == R_IP),
        .wr_ie     (csr_we && sel == R_IE),
        .wdata     (csr_wdata),
        .dmask     (deleg_mask),
        .hw_ext    (hw_ext_pend),
        .hw_tim    (hw_tim_pend),
        .hw_sw_set (hw_sw_set),
        .pend_o    (irq_pend_o),
        .en_o      (irq_en_o),
        .ip_view_o (ip_view),
        .ie_view_o (ie_view)
    );

    uirq_trap_regs #(.XLEN(XLEN)) u_trap (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (csr_we),
        .sel     (sel),
        .wdata   (csr_wdata),
        .tvec_o  (tvec_q),
        .scr_o   (scr_q),
        .epc_o   (epc_q),
        .cause_o (cause_q),
        .tval_o  (tval_q)
    );

    always_comb begin
        case (sel)
            R_STAT:  csr_rdata = stat_view;
            R_IE:    csr_rdata = ie_view;
            R_IP:    csr_rdata = ip_view;
            R_TVEC:  csr_rdata = tvec_q;
            R_SCR:   csr_rdata = scr_q;
            R_EPC:   csr_rdata = epc_q;
            R_CAUSE: csr_rdata = cause_q;
            R_TVAL:  csr_rdata = tval_q;
            default: csr_rdata = '0;
        endcase
    end

    assign csr_illegal = (sel == R_NONE);

    // R8: an unknown address reads as zero
    p_illegal_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> (csr_rdata == '0));

    // R1: the status window shows nothing outside its two bits
    p_stat_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == ADR_STAT) |-> ((csr_rdata & ~STAT_POS_MASK) == '0));

    // R3: the pending window shows only delegated kind positions
    p_ip_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == ADR_IP) |-> ((csr_rdata & ~(KIND_POS_MASK & deleg_mask)) == '0));

    // R4: the enable window shows only delegated kind positions
    p_ie_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == ADR_IE) |-> ((csr_rdata & ~(KIND_POS_MASK & deleg_mask)) == '0));

endmodule

// File: tb/test_user_irq_csr.sv
`timescale 1ns/1ps
module test_user_irq_csr;

    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [11:0]     csr_addr = '0;
    logic            csr_we = 1'b0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [XLEN-1:0] csr_rdata;
    logic            csr_illegal;
    logic [XLEN-1:0] deleg_mask = '0;
    logic            hw_ext_pend = 1'b0;
    logic            hw_tim_pend = 1'b0;
    logic            hw_sw_set = 1'b0;
    logic            m_status_ld = 1'b0;
    logic [XLEN-1:0] m_status_val = '0;
    logic [XLEN-1:0] status_o;
    logic [2:0]      irq_pend_o;
    logic [2:0]      irq_en_o;

    user_irq_csr #(.XLEN(XLEN)) i_user_irq_csr (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
        .deleg_mask(deleg_mask), .hw_ext_pend(hw_ext_pend), .hw_tim_pend(hw_tim_pend),
        .hw_sw_set(hw_sw_set), .m_status_ld(m_status_ld), .m_status_val(m_status_val),
        .status_o(status_o), .irq_pend_o(irq_pend_o), .irq_en_o(irq_en_o)
    );

    always #2.5 clk = ~clk;

    // sel: 0 = read data + illegal flag, 1 = status_o, 2 = irq_pend_o, 3 = irq_en_o
    typedef struct {
        int          sel;
        logic [31:0] exp;
        logic        exp_ill;
        string       req;
    } item_t;

    item_t sb[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic idle();
        csr_we      = 1'b0;
        m_status_ld = 1'b0;
        hw_sw_set   = 1'b0;
    endtask

    task automatic push(int s, logic [31:0] e, logic il, string r);
        item_t it;
        it.sel = s; it.exp = e; it.exp_ill = il; it.req = r;
        sb.push_back(it);
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] e, logic il, string r);
        @(negedge clk); idle();
        csr_addr = a;
        push(0, e, il, r);
    endtask

    task automatic chk(int s, logic [31:0] e, string r);
        @(negedge clk); idle();
        push(s, e, 1'b0, r);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk); idle();
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    endtask

    task automatic set_mask(logic [31:0] m);
        @(negedge clk); idle();
        deleg_mask = m;
    endtask

    // monitor: compare one expected item per cycle, 1 ns after the falling edge
    always @(negedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            logic [32:0] got, want;
            it = sb.pop_front();
            case (it.sel)
                0:       begin got = {csr_illegal, csr_rdata}; want = {it.exp_ill, it.exp}; end
                1:       begin got = {1'b0, status_o};         want = {1'b0, it.exp}; end
                2:       begin got = {30'd0, irq_pend_o};      want = {1'b0, it.exp}; end
                default: begin got = {30'd0, irq_en_o};        want = {1'b0, it.exp}; end
            endcase
            n_cmp++;
            if (got !== want) begin
                n_bad++;
                $display("FAIL %s: sel %0d got %h expected %h", it.req, it.sel, got, want);
            end
        end
    end

    initial begin
        #12 rst_n = 1'b1;

        // R12: everything cleared by reset
        rd(12'h000, 32'h0, 1'b0, "R12");
        rd(12'h004, 32'h0, 1'b0, "R12");
        rd(12'h005, 32'h0, 1'b0, "R12");
        rd(12'h040, 32'h0, 1'b0, "R12");
        rd(12'h041, 32'h0, 1'b0, "R12");
        rd(12'h042, 32'h0, 1'b0, "R12");
        rd(12'h043, 32'h0, 1'b0, "R12");
        rd(12'h044, 32'h0, 1'b0, "R12");
        chk(1, 32'h0, "R12");
        chk(2, 32'h0, "R12");
        chk(3, 32'h0, "R12");

        // R2 / R1: machine load, then user status window
        @(negedge clk); idle(); m_status_ld = 1'b1; m_status_val = 32'hFFFF_FFFF;
        chk(1, 32'hFFFF_FFFF, "R2");
        rd(12'h000, 32'h0000_0011, 1'b0, "R1");
        wr(12'h000, 32'h0000_0000);
        chk(1, 32'hFFFF_FFEE, "R2");
        rd(12'h000, 32'h0, 1'b0, "R1");
        // R2: machine load and user write in the same cycle
        @(negedge clk); idle();
        m_status_ld = 1'b1; m_status_val = 32'h0000_0100;
        csr_we = 1'b1; csr_addr = 12'h000; csr_wdata = 32'h0000_0011;
        chk(1, 32'h0000_0100, "R2");
        wr(12'h000, 32'hFFFF_FFFF);
        chk(1, 32'h0000_0111, "R2");
        rd(12'h000, 32'h0000_0011, 1'b0, "R1");

        // R6 / R4: enable writes and masked reads
        set_mask(32'h0000_0110);
        wr(12'h004, 32'h0000_FFFF);
        chk(3, 32'h6, "R6");
        set_mask(32'h0000_0111);
        rd(12'h004, 32'h0000_0110, 1'b0, "R4");
        set_mask(32'h0000_0001);
        wr(12'h004, 32'h0000_0000);
        chk(3, 32'h6, "R6");
        set_mask(32'h0000_0111);
        wr(12'h004, 32'h0000_0001);
        chk(3, 32'h1, "R6");
        set_mask(32'h0000_0100);
        rd(12'h004, 32'h0, 1'b0, "R4");
        set_mask(32'h0000_0001);
        rd(12'h004, 32'h0000_0001, 1'b0, "R4");

        // R5 / R3: hardware levels and pending window
        @(negedge clk); idle(); hw_ext_pend = 1'b1; hw_tim_pend = 1'b1;
        chk(2, 32'h6, "R5");
        set_mask(32'h0000_0111);
        rd(12'h044, 32'h0000_0110, 1'b0, "R3");
        set_mask(32'h0000_0010);
        rd(12'h044, 32'h0000_0010, 1'b0, "R3");
        set_mask(32'h0000_0111);
        wr(12'h044, 32'h0000_FFFF);
        chk(2, 32'h7, "R5");
        @(negedge clk); idle(); hw_ext_pend = 1'b0;
        chk(2, 32'h3, "R5");
        wr(12'h044, 32'h0000_0110);
        chk(2, 32'h2, "R5");
        set_mask(32'h0000_0110);
        wr(12'h044, 32'h0000_0001);
        chk(2, 32'h2, "R5");
        rd(12'h044, 32'h0000_0010, 1'b0, "R3");

        // R7: hardware set, then write wins over a simultaneous set
        @(negedge clk); idle(); hw_sw_set = 1'b1;
        chk(2, 32'h3, "R7");
        set_mask(32'h0000_0111);
        @(negedge clk); idle();
        hw_sw_set = 1'b1; csr_we = 1'b1; csr_addr = 12'h044; csr_wdata = 32'h0;
        chk(2, 32'h2, "R7");

        // R10: trap vector mode legalization
        wr(12'h005, 32'h1000_0002);
        rd(12'h005, 32'h1000_0000, 1'b0, "R10");
        wr(12'h005, 32'h2000_0003);
        rd(12'h005, 32'h2000_0000, 1'b0, "R10");
        wr(12'h005, 32'h3000_0001);
        rd(12'h005, 32'h3000_0001, 1'b0, "R10");

        // R9: exception PC and plain registers
        wr(12'h041, 32'h8000_0003);
        rd(12'h041, 32'h8000_0002, 1'b0, "R9");
        wr(12'h040, 32'hDEAD_BEEF);
        rd(12'h040, 32'hDEAD_BEEF, 1'b0, "R9");
        wr(12'h042, 32'h8000_0007);
        rd(12'h042, 32'h8000_0007, 1'b0, "R9");
        wr(12'h043, 32'h1234_5678);
        rd(12'h043, 32'h1234_5678, 1'b0, "R9");

        // R11: read during a write sees the old value
        @(negedge clk); idle();
        csr_we = 1'b1; csr_addr = 12'h040; csr_wdata = 32'h0000_0005;
        push(0, 32'hDEAD_BEEF, 1'b0, "R11");
        rd(12'h040, 32'h0000_0005, 1'b0, "R11");

        // R8: unknown addresses
        rd(12'h300, 32'h0, 1'b1, "R8");
        rd(12'h001, 32'h0, 1'b1, "R8");
        rd(12'h045, 32'h0, 1'b1, "R8");
        wr(12'h300, 32'hFFFF_FFFF);
        rd(12'h040, 32'h0000_0005, 1'b0, "R8");
        chk(1, 32'h0000_0111, "R8");

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule